// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is a shift-register counter that moves a single set bit around a register of `WIDTH` bits. Each step moves the token one place toward bit 0, and the token leaving bit 0 re-enters at the top bit. The result is `WIDTH` distinct states. Each output bit is high for one cycle out of every `WIDTH`, so the outputs together form a `WIDTH`-phase timing signal. A typical use is sequencing a fixed set of slots without a binary decode.

The bit fed into the top of the register is not a copy of the bit that leaves. It is 1 only when every bit above bit 0 is clear. Because of this, the counter recovers from any corrupted contents, such as all zeros or several ones left by an upset or by a non-default reset pattern. Once the contents are legal, the counter behaves exactly like a plain rotating ring.

The synchronous enable advances the counter one step per clock. The reset pattern is a parameter, and by default it is a single one in bit 0.

Top module: `ring_sc_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `phase` loads `RESET_PATTERN` (default: only bit 0 set, 0001 for four bits). Reset takes priority over `en`.
- R2: When `en` is high and `phase` holds exactly one set bit, each edge moves that bit one position toward bit 0, and bit 0 wraps to bit `WIDTH-1`. For four bits the sequence is 0001, 1000, 0100, 0010, 0001.
- R3: When `en` is low and reset is not asserted, `phase` keeps its value across the edge, whether or not that value is legal.
- R4: From a legal state with `en` held high, `phase` returns to its starting value after exactly `WIDTH` edges, and each bit is high in exactly one of those `WIDTH` states.
- R5: On an enabled edge, bits `WIDTH-2..0` take the previous bits `WIDTH-1..1`. Bit `WIDTH-1` becomes 1 only if the previous bits `WIDTH-1..1` were all 0, and becomes 0 otherwise.
- R6: From all zeros, a single enabled edge gives the state with only bit `WIDTH-1` set.
- R7: From any pattern with more than one set bit, the counter holds exactly one set bit within `WIDTH-1` enabled edges. Examples for four bits: 1111 goes to 0111, 0011, 0001; 1010 goes to 0101, 0010.
- R8: Once `phase` has exactly one set bit, it keeps exactly one set bit on every later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance one step on this edge when high |
| phase | output | WIDTH | Counter register; one bit per phase |

## Verification
The embedded properties check on every enabled edge that the shift moves bits down and that the top bit follows the all-clear rule. They also check that legal states rotate and stay legal, that all zeros recover in one step, and that the enable low holds the state. A run counter checks that an illegal state never lasts beyond `WIDTH-1` enabled edges. The exact recovery paths from specific illegal patterns, the full period, the phase coverage and reset priority over enable can only be shown by the bench. It does this by driving instances that reset into zero, all-ones and mixed patterns, and by comparing their outputs with hand-computed sequences.

// File: rtl/ring_sc_pkg.sv
// Package: shared helpers for the self-correcting ring counter.
// Assumes counter widths of at most MAX_WIDTH bits.
package ring_sc_pkg;
    localparam int MAX_WIDTH = 64;

    // Returns 1 when exactly one bit of the zero-extended vector is set.
    function automatic logic is_one_hot(input logic [MAX_WIDTH-1:0] v);
        int ones;
        ones = 0;
        for (int i = 0; i < MAX_WIDTH; i++) begin
            ones += int'(v[i]);
        end
        return (ones == 1);
    endfunction
endpackage

// File: rtl/ring_sc_feedback.sv
// Module: serial-input generator for the ring counter.
// Drives a 1 only when every bit that will stay in the register
// (all bits above bit 0) is clear. Assumes WIDTH >= 2.
module ring_sc_feedback #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-2:0] upper_bits,
    output logic             ser_bit
);
    // Wide NOR over the retained bits.
    always_comb begin
        ser_bit = ~|upper_bits;
    end
endmodule

// File: rtl/ring_sc_shift_reg.sv
// Module: state register with a shift toward bit 0.
// The serial bit enters at the top. Assumes WIDTH >= 2 and that
// ser_bit is valid in every cycle. Reset is synchronous, active low.
module ring_sc_shift_reg #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ser_bit,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // Per-bit next-state selection: top bit from the feedback, others from the bit above.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign nxt[i] = ser_bit;
        end else begin : g_mid
            assign nxt[i] = q[i+1];
        end
    end

    // State update: reset wins, then the enable gates the shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (en) begin
            q <= nxt;
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

    // R5
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));
endmodule

// File: rtl/ring_sc_counter.sv
// Module: self-correcting one-hot ring counter (top).
// Produces a WIDTH-phase one-hot sequence that moves toward bit 0, and
// converges to it from any register contents. Assumes 2 <= WIDTH <= 64.
// Reset is synchronous, active low.
module ring_sc_counter #(
    parameter int               WIDTH         = 4,
    parameter logic [WIDTH-1:0] RESET_PATTERN = WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] phase
);
    import ring_sc_pkg::*;

    localparam int               RUN_W    = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic ser_bit;

    ring_sc_feedback #(.WIDTH(WIDTH)) u_fb (
        .upper_bits (phase[WIDTH-1:1]),
        .ser_bit    (ser_bit)
    );

    ring_sc_shift_reg #(.WIDTH(WIDTH), .RST_VAL(RESET_PATTERN)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ser_bit (ser_bit),
        .q       (phase)
    );

    // Checker state: enabled edges spent so far in an illegal pattern.
    logic [RUN_W-1:0] bad_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_run <= '0;
        end else if (en) begin
            bad_run <= is_one_hot(MAX_WIDTH'(phase)) ? '0 : bad_run + 1'b1;
        end
    end

    // R2
    legal_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_one_hot(MAX_WIDTH'(phase)))
        |=> phase == {$past(phase[0]), $past(phase[WIDTH-1:1])});

    // R5
    top_bit_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase[WIDTH-1] == ($past(phase[WIDTH-1:1]) == '0));

    // R6
    zero_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == '0) |=> phase == TOP_ONLY);

    // R7
    converge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_run < RUN_W'(WIDTH));

    // R8
    legal_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_one_hot(MAX_WIDTH'(phase)) |=> is_one_hot(MAX_WIDTH'(phase)));
endmodule

// File: tb/tb_ring_sc_counter.sv
module tb_ring_sc_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic en_x = 1'b0;
    logic [3:0] phase, q_zero, q_many, q_mix;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ring_sc_counter #(.WIDTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .phase(phase));
    ring_sc_counter #(.WIDTH(4), .RESET_PATTERN(4'b0000)) dut_zero (
        .clk(clk), .rst_n(rst_n), .en(en_x), .phase(q_zero));
    ring_sc_counter #(.WIDTH(4), .RESET_PATTERN(4'b1111)) dut_many (
        .clk(clk), .rst_n(rst_n), .en(en_x), .phase(q_many));
    ring_sc_counter #(.WIDTH(4), .RESET_PATTERN(4'b1010)) dut_mix (
        .clk(clk), .rst_n(rst_n), .en(en_x), .phase(q_mix));

    // Table entries: {en, expected phase after the edge}. R2 rotation, R3 holds.
    localparam logic [4:0] VEC [12] = '{
        5'b1_1000, 5'b1_0100, 5'b0_0100, 5'b1_0010, 5'b1_0001, 5'b0_0001,
        5'b1_1000, 5'b1_0100, 5'b1_0010, 5'b1_0001, 5'b1_1000, 5'b0_1000};

    // Expected recovery sequences over four enabled edges (R6, R7).
    localparam logic [3:0] EXP_ZERO [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
    localparam logic [3:0] EXP_MANY [4] = '{4'b0111, 4'b0011, 4'b0001, 4'b1000};
    localparam logic [3:0] EXP_MIX  [4] = '{4'b0101, 4'b0010, 4'b0001, 4'b1000};

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] start;
        logic [3:0] seen;
        int period;

        // R1: reset state of every instance
        edge_step();
        edge_step();
        chk("R1 default reset", phase, 4'b0001);
        chk("R1 zero reset", q_zero, 4'b0000);
        chk("R1 many reset", q_many, 4'b1111);
        chk("R1 mix reset", q_mix, 4'b1010);
        @(negedge clk) rst_n = 1'b1;

        // R2 / R3: vector table
        for (int i = 0; i < 12; i++) begin
            @(negedge clk) en = VEC[i][4];
            edge_step();
            chk(VEC[i][4] ? "R2 rotate" : "R3 hold", phase, VEC[i][3:0]);
        end

        // R3: illegal patterns held while their enable is low
        chk("R3 hold zero", q_zero, 4'b0000);
        chk("R3 hold many", q_many, 4'b1111);
        chk("R3 hold mix", q_mix, 4'b1010);

        // R1: reset beats enable mid-sequence
        @(negedge clk) begin rst_n = 1'b0; en = 1'b1; end
        edge_step();
        chk("R1 reset priority", phase, 4'b0001);
        @(negedge clk) rst_n = 1'b1;

        // R4: period and phase coverage
        start = phase;
        seen = '0;
        period = 0;
        for (int k = 0; k < 8; k++) begin
            seen |= phase;
            edge_step();
            period++;
            if (phase == start) break;
        end
        chk("R4 period", 4'(period), 4'd4);
        chk("R4 every phase", seen, 4'b1111);
        @(negedge clk) en = 1'b0;

        // R5 / R6 / R7: recovery from illegal starts
        @(negedge clk) en_x = 1'b1;
        for (int k = 0; k < 4; k++) begin
            edge_step();
            chk("R6 zero recovery", q_zero, EXP_ZERO[k]);
            chk("R7 many-ones recovery", q_many, EXP_MANY[k]);
            chk("R5 mixed shift", q_mix, EXP_MIX[k]);
        end

        // R8: recovered instances keep one set bit
        for (int k = 0; k < 4; k++) begin
            edge_step();
            chk("R8 stays legal", 4'($countones(q_many)), 4'd1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule